// File: doc/BRIEF.md
# Multicycle Functional-Unit Issue Controller

This block sits in the decode stage of an in-order pipeline. The pipeline has four execution units, and none of them is pipelined. Unit 0 is the integer unit and finishes in one cycle. Unit 1 is the multiplier, unit 2 is the floating-point adder and unit 3 is the divider; by default each of these takes four cycles. Every cycle the decoder presents one instruction: the unit it targets, an optional destination, and up to two optional sources. Each register operand is a class bit (0 = integer file, 1 = FP file) together with a 5-bit index. The controller decides whether that instruction may leave decode, fires the start pulse of the target unit, and lets one finished unit at a time use the single writeback port. The arithmetic is not modelled; each unit is a down-counter.

Each unit runs its own small state machine with three states: `U_IDLE`, `U_EXEC` and `U_HOLD`.
- LAUNCH moves `U_IDLE` to `U_EXEC` on a start pulse. It loads the counter with latency-1 and records the destination tag.
- TICK keeps the unit in `U_EXEC` while the counter is above zero and decrements it.
- At zero the unit requests the writeback port. FINISH returns it to `U_IDLE` if the grant is won.
- DEFER moves it to `U_HOLD` if the grant is lost. In `U_HOLD` the request stays up.
- RETIRE returns `U_HOLD` to `U_IDLE` on a grant.

A unit counts as busy, and its destination as in flight, in every state except `U_IDLE`. The decoder keeps the same instruction on its inputs until it sees the issue signal. That is what keeps issue in order.

Top module: `mfu_issue_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, no unit is busy and `wb_grant` is 0. With no hazard present, `issue_ok` equals `dec_valid`.
- R2: `issue_ok` is low whenever `dec_valid` is low or the target unit (`dec_unit`: 0 integer, 1 multiplier, 2 FP adder, 3 divider) is busy. A unit is free again from the cycle after its writeback grant.
- R3: `issue_ok` is low while an enabled source of the decoded instruction has the same class and index as the destination of a busy unit.
- R4: `issue_ok` is low while the decoded instruction's enabled destination has the same class and index as the destination of a busy unit. The stall lasts until that unit has been granted writeback.
- R5: An integer and an FP register with the same index never conflict. A source or destination whose enable bit is low is ignored by the hazard checks.
- R6: `unit_start` is one-hot at bit `dec_unit` in exactly the cycles where `issue_ok` is high, and zero otherwise. A stalled instruction therefore starts nothing, and the instructions behind it wait too.
- R7: A unit issued in cycle t requests writeback in cycle t+L, where L is its latency. It cannot be granted earlier.
- R8: `wb_grant` is zero or one-hot. Among the units requesting, it goes to the one with the longest latency; when latencies are equal, the higher unit number wins.
- R9: A unit that loses arbitration keeps requesting and stays busy, and so keeps blocking its destination, until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decoded instruction present |
| dec_unit | input | 2 | Target unit number |
| dec_dst_en | input | 1 | Instruction writes a register |
| dec_dst_fp | input | 1 | Destination class (1 = FP) |
| dec_dst | input | 5 | Destination index |
| dec_sa_en | input | 1 | First source used |
| dec_sa_fp | input | 1 | First source class |
| dec_sa | input | 5 | First source index |
| dec_sb_en | input | 1 | Second source used |
| dec_sb_fp | input | 1 | Second source class |
| dec_sb | input | 5 | Second source index |
| issue_ok | output | 1 | Instruction leaves decode this cycle |
| unit_start | output | 4 | Start pulse per unit |
| wb_grant | output | 4 | One-hot writeback grant |

## Verification
The bench goes after several corner cases, each of which a specific bug would expose:
- Two back-to-back multiplies. A design that frees a unit too early would start the second while the first still runs.
- An integer result read by the very next instruction. A design that clears the in-flight destination on the request rather than on the grant would issue one cycle early.
- A chain in which an integer operation finishes alongside each 4-cycle unit in turn. It is built so that a wrong priority order, or a loser that drops its request, shows up as a missing or misplaced grant.
- Two accesses with the same index but opposite register classes, and operands whose enable bit is low. A design that compares indices alone, or ignores the enable bits, would stall here when it should not.

// File: rtl/mfu_issue_pkg.sv
package mfu_issue_pkg;

    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned NUM_UNITS = 4;
    localparam int unsigned UNIT_W    = 2;

    typedef enum logic [1:0] {
        U_IDLE = 2'd0,
        U_EXEC = 2'd1,
        U_HOLD = 2'd2
    } slot_state_e;

    typedef struct packed {
        logic                 fp;
        logic [REG_IDX_W-1:0] idx;
    } reg_tag_t;

endpackage

// File: rtl/mfu_unit_slot.sv
module mfu_unit_slot
    import mfu_issue_pkg::*;
#(
    parameter int unsigned LAT   = 4,
    parameter int unsigned CNT_W = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     start_has_dst,
    input  reg_tag_t start_tag,
    input  logic     grant,
    output logic     wb_req,
    output logic     busy,
    output logic     dst_live,
    output reg_tag_t dst_tag
);

    slot_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             has_dst_q;
    reg_tag_t         tag_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            U_IDLE: begin
                if (start) begin                       // LAUNCH
                    state_d = U_EXEC;
                    cnt_d   = CNT_W'(LAT - 1);
                end
            end
            U_EXEC: begin
                if (cnt_q != '0) begin                 // TICK
                    cnt_d = cnt_q - 1'b1;
                end else if (grant) begin              // FINISH
                    state_d = U_IDLE;
                end else begin                         // DEFER
                    state_d = U_HOLD;
                end
            end
            U_HOLD: begin
                if (grant) state_d = U_IDLE;           // RETIRE
            end
            default: state_d = U_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= U_IDLE;
            cnt_q     <= '0;
            has_dst_q <= 1'b0;
            tag_q     <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (start && state_q == U_IDLE) begin
                has_dst_q <= start_has_dst;
                tag_q     <= start_tag;
            end
        end
    end

    // outputs
    always_comb begin
        wb_req   = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            U_IDLE:  busy   = 1'b0;
            U_EXEC:  wb_req = (cnt_q == '0);
            U_HOLD:  wb_req = 1'b1;
            default: busy   = 1'b0;
        endcase
        dst_live = busy & has_dst_q;
        dst_tag  = tag_q;
    end

endmodule

// File: rtl/mfu_wb_arbiter.sv
module mfu_wb_arbiter #(
    parameter int unsigned           N       = 4,
    parameter int unsigned           LW      = 8,
    parameter logic [N*LW-1:0]       LAT_VEC = '0
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    // a requester loses to any other requester that is slower,
    // or equally slow with a higher unit number
    always_comb begin
        for (int i = 0; i < N; i++) begin
            grant[i] = req[i];
            for (int j = 0; j < N; j++) begin
                if (j != i && req[j]) begin
                    if (LAT_VEC[j*LW +: LW] > LAT_VEC[i*LW +: LW])
                        grant[i] = 1'b0;
                    else if (LAT_VEC[j*LW +: LW] == LAT_VEC[i*LW +: LW] && j > i)
                        grant[i] = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/mfu_hazard_check.sv
module mfu_hazard_check
    import mfu_issue_pkg::*;
#(
    parameter int unsigned N = 4
) (
    input  logic                 sa_en,
    input  reg_tag_t             sa_tag,
    input  logic                 sb_en,
    input  reg_tag_t             sb_tag,
    input  logic                 dst_en,
    input  reg_tag_t             dst_tag,
    input  logic     [N-1:0]     live,
    input  reg_tag_t [N-1:0]     live_tag,
    output logic                 raw_hit,
    output logic                 waw_hit
);

    logic [N-1:0] raw_u, waw_u;

    for (genvar u = 0; u < N; u++) begin : g_cmp
        assign raw_u[u] = live[u] & ((sa_en & (sa_tag == live_tag[u])) |
                                     (sb_en & (sb_tag == live_tag[u])));
        assign waw_u[u] = live[u] & dst_en & (dst_tag == live_tag[u]);
    end

    assign raw_hit = |raw_u;
    assign waw_hit = |waw_u;

endmodule

// File: rtl/mfu_issue_ctrl.sv
module mfu_issue_ctrl
    import mfu_issue_pkg::*;
#(
    parameter int unsigned LAT_INT  = 1,
    parameter int unsigned LAT_MUL  = 4,
    parameter int unsigned LAT_FADD = 4,
    parameter int unsigned LAT_DIV  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dec_valid,
    input  logic [1:0] dec_unit,
    input  logic       dec_dst_en,
    input  logic       dec_dst_fp,
    input  logic [4:0] dec_dst,
    input  logic       dec_sa_en,
    input  logic       dec_sa_fp,
    input  logic [4:0] dec_sa,
    input  logic       dec_sb_en,
    input  logic       dec_sb_fp,
    input  logic [4:0] dec_sb,
    output logic       issue_ok,
    output logic [3:0] unit_start,
    output logic [3:0] wb_grant
);

    localparam int unsigned LW = 8;
    localparam int unsigned MAX_LAT =
        (LAT_INT > LAT_MUL ? LAT_INT : LAT_MUL) > (LAT_FADD > LAT_DIV ? LAT_FADD : LAT_DIV) ?
        (LAT_INT > LAT_MUL ? LAT_INT : LAT_MUL) : (LAT_FADD > LAT_DIV ? LAT_FADD : LAT_DIV);
    localparam int unsigned CNT_W = (MAX_LAT < 2) ? 1 : $clog2(MAX_LAT);
    localparam logic [NUM_UNITS*LW-1:0] LAT_VEC =
        {LW'(LAT_DIV), LW'(LAT_FADD), LW'(LAT_MUL), LW'(LAT_INT)};

    logic     [NUM_UNITS-1:0] busy, live, req;
    reg_tag_t [NUM_UNITS-1:0] live_tag;
    reg_tag_t                 dst_t, sa_t, sb_t;
    logic                     raw_hit, waw_hit;

    assign dst_t = '{fp: dec_dst_fp, idx: dec_dst};
    assign sa_t  = '{fp: dec_sa_fp,  idx: dec_sa};
    assign sb_t  = '{fp: dec_sb_fp,  idx: dec_sb};

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        localparam int unsigned L = LAT_VEC[u*LW +: LW];
        mfu_unit_slot #(.LAT(L), .CNT_W(CNT_W)) u_slot (
            .clk           (clk),
            .rst_n         (rst_n),
            .start         (unit_start[u]),
            .start_has_dst (dec_dst_en),
            .start_tag     (dst_t),
            .grant         (wb_grant[u]),
            .wb_req        (req[u]),
            .busy          (busy[u]),
            .dst_live      (live[u]),
            .dst_tag       (live_tag[u])
        );
    end

    mfu_wb_arbiter #(.N(NUM_UNITS), .LW(LW), .LAT_VEC(LAT_VEC)) u_arb (
        .req   (req),
        .grant (wb_grant)
    );

    mfu_hazard_check #(.N(NUM_UNITS)) u_haz (
        .sa_en    (dec_sa_en),
        .sa_tag   (sa_t),
        .sb_en    (dec_sb_en),
        .sb_tag   (sb_t),
        .dst_en   (dec_dst_en),
        .dst_tag  (dst_t),
        .live     (live),
        .live_tag (live_tag),
        .raw_hit  (raw_hit),
        .waw_hit  (waw_hit)
    );

    always_comb begin
        issue_ok   = dec_valid & ~busy[dec_unit] & ~raw_hit & ~waw_hit;
        unit_start = '0;
        if (issue_ok) unit_start[dec_unit] = 1'b1;
    end

endmodule

// File: rtl/mfu_issue_checker.sv
module mfu_issue_checker #(
    parameter int unsigned LAT_INT  = 1,
    parameter int unsigned LAT_MUL  = 4,
    parameter int unsigned LAT_FADD = 4,
    parameter int unsigned LAT_DIV  = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       dec_valid,
    input logic [1:0] dec_unit,
    input logic       issue_ok,
    input logic [3:0] unit_start,
    input logic [3:0] wb_grant
);

    localparam int unsigned LATS [4] = '{LAT_INT, LAT_MUL, LAT_FADD, LAT_DIV};

    logic [3:0] pend;
    logic [7:0] age [4];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            for (int i = 0; i < 4; i++) age[i] <= '0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (unit_start[i]) begin
                    pend[i] <= 1'b1;
                    age[i]  <= '0;
                end else begin
                    if (wb_grant[i]) pend[i] <= 1'b0;
                    if (pend[i] && age[i] != 8'hff) age[i] <= age[i] + 1'b1;
                end
            end
        end
    end

    a_r2_issue_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ok |-> dec_valid);

    a_r6_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unit_start) && ((|unit_start) == issue_ok));

    a_r6_start_on_target: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ok |-> unit_start[dec_unit]);

    a_r8_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_grant));

    for (genvar u = 0; u < 4; u++) begin : g_unit_chk
        a_r2_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
            unit_start[u] |-> !pend[u]);
        a_r9_grant_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
            wb_grant[u] |-> pend[u]);
        a_r7_min_latency: assert property (@(posedge clk) disable iff (!rst_n)
            wb_grant[u] |-> (32'(age[u]) + 1 >= LATS[u]));
    end

endmodule

bind mfu_issue_ctrl mfu_issue_checker #(
    .LAT_INT(LAT_INT), .LAT_MUL(LAT_MUL), .LAT_FADD(LAT_FADD), .LAT_DIV(LAT_DIV)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_valid  (dec_valid),
    .dec_unit   (dec_unit),
    .issue_ok   (issue_ok),
    .unit_start (unit_start),
    .wb_grant   (wb_grant)
);

// File: tb/tb_mfu_issue_ctrl.sv
module tb_mfu_issue_ctrl;

    typedef struct {
        int unit;
        bit de; bit dfp; int dst;
        bit ae; bit afp; int a;
        bit be; bit bfp; int b;
        bit vld;
    } ins_t;

    localparam int N_DIR   = 16;
    localparam int N_RAND  = 400;
    localparam int LIMIT   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dec_valid = 1'b0;
    logic [1:0] dec_unit = '0;
    logic       dec_dst_en = 1'b0, dec_dst_fp = 1'b0;
    logic [4:0] dec_dst = '0;
    logic       dec_sa_en = 1'b0, dec_sa_fp = 1'b0;
    logic [4:0] dec_sa = '0;
    logic       dec_sb_en = 1'b0, dec_sb_fp = 1'b0;
    logic [4:0] dec_sb = '0;
    logic       issue_ok;
    logic [3:0] unit_start, wb_grant;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    mfu_issue_ctrl dut (.*);

    // reference model state
    int lat   [4] = '{1, 4, 4, 4};
    bit mbusy [4];
    int mcnt  [4];
    bit mde   [4];
    bit mdfp  [4];
    int mdst  [4];

    function automatic ins_t mk(int u, bit de, bit dfp, int d,
                                bit ae, bit afp, int a, bit be, bit bfp, int b);
        ins_t t;
        t.unit = u; t.de = de; t.dfp = dfp; t.dst = d;
        t.ae = ae; t.afp = afp; t.a = a; t.be = be; t.bfp = bfp; t.b = b;
        t.vld = 1;
        return t;
    endfunction

    function automatic ins_t directed(int i);
        case (i)
            0:  return mk(1, 1, 1, 1,  1, 1, 2,  1, 1, 3);  // mul f1
            1:  return mk(1, 1, 1, 4,  1, 1, 5,  1, 1, 6);  // mul again: unit busy (R2)
            2:  return mk(0, 1, 0, 1,  1, 0, 2,  0, 0, 0);  // int r1
            3:  return mk(0, 1, 0, 3,  1, 0, 1,  0, 0, 0);  // reads r1 (R3)
            4:  return mk(2, 1, 1, 7,  1, 1, 4,  0, 0, 0);  // reads f4 (R3)
            5:  return mk(3, 1, 1, 8,  1, 1, 9,  0, 0, 0);  // div f8
            6:  return mk(2, 1, 1, 8,  1, 1, 2,  0, 0, 0);  // writes f8 again (R4)
            7:  return mk(0, 1, 0, 8,  1, 0, 8,  0, 1, 8);  // r8 vs f8, disabled f8 (R5)
            8:  return mk(1, 1, 1, 10, 0, 0, 0,  0, 0, 0);  // collision chain (R8 R9)
            9:  return mk(2, 1, 1, 11, 0, 0, 0,  0, 0, 0);
            10: return mk(3, 1, 1, 12, 0, 0, 0,  0, 0, 0);
            11: return mk(0, 1, 0, 5,  0, 0, 0,  0, 0, 0);
            12: return mk(0, 1, 0, 6,  1, 0, 5,  0, 0, 0);
            13: return mk(0, 0, 1, 12, 0, 1, 10, 0, 1, 11); // all disabled (R5)
            14: return mk(0, 1, 0, 7,  0, 0, 0,  1, 1, 12); // reads f12 (R3)
            default: return mk(3, 1, 0, 9, 1, 1, 12, 1, 0, 6);
        endcase
    endfunction

    function automatic ins_t random_ins();
        ins_t t;
        t = mk(int'($urandom_range(3, 0)),
               bit'($urandom_range(3, 0) != 0), bit'($urandom_range(1, 0)), int'($urandom_range(3, 0)),
               bit'($urandom_range(1, 0)), bit'($urandom_range(1, 0)), int'($urandom_range(3, 0)),
               bit'($urandom_range(1, 0)), bit'($urandom_range(1, 0)), int'($urandom_range(3, 0)));
        t.vld = ($urandom_range(4, 0) != 0);
        return t;
    endfunction

    task automatic check_bit(string req, int act, int exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp_v, $time);
        end
    endtask

    task automatic drive(ins_t t);
        dec_valid  = t.vld;
        dec_unit   = 2'(t.unit);
        dec_dst_en = t.de;  dec_dst_fp = t.dfp; dec_dst = 5'(t.dst);
        dec_sa_en  = t.ae;  dec_sa_fp  = t.afp; dec_sa  = 5'(t.a);
        dec_sb_en  = t.be;  dec_sb_fp  = t.bfp; dec_sb  = 5'(t.b);
    endtask

    initial begin : watchdog
        #(8 * (LIMIT + 2000));
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : main
        ins_t cur;
        int   pc;
        int   cyc;
        void'($urandom(32'h1d2c));
        for (int i = 0; i < 4; i++) begin
            mbusy[i] = 0; mcnt[i] = 0; mde[i] = 0; mdfp[i] = 0; mdst[i] = 0;
        end
        repeat (3) @(negedge clk);
        #1;
        check_bit("R1 grant in reset", int'(wb_grant), 0);
        check_bit("R1 issue in reset", int'(issue_ok), 0);
        rst_n = 1'b1;

        pc  = 0;
        cur = directed(0);
        cyc = 0;
        while (pc < N_DIR + N_RAND && cyc < LIMIT) begin
            bit   raw, waw, exp_iss;
            bit   req [4];
            int   best;
            int   exp_g, exp_s;
            @(negedge clk);
            drive(cur);
            #1;
            best = -1;
            for (int i = 0; i < 4; i++) begin
                req[i] = mbusy[i] && (mcnt[i] == 0);
                if (req[i] && (best < 0 || lat[i] >= lat[best])) best = i;
            end
            raw = 0; waw = 0;
            for (int i = 0; i < 4; i++) begin
                if (mbusy[i] && mde[i]) begin
                    if (cur.ae && cur.afp == mdfp[i] && cur.a == mdst[i]) raw = 1;
                    if (cur.be && cur.bfp == mdfp[i] && cur.b == mdst[i]) raw = 1;
                    if (cur.de && cur.dfp == mdfp[i] && cur.dst == mdst[i]) waw = 1;
                end
            end
            exp_iss = cur.vld && !mbusy[cur.unit] && !raw && !waw;
            exp_g = (best < 0) ? 0 : (1 << best);
            exp_s = exp_iss ? (1 << cur.unit) : 0;
            if (cyc == 0)
                check_bit("R1 first cycle grant", int'(wb_grant), 0);
            check_bit("issue_ok R2 R3 R4 R5", int'(issue_ok), int'(exp_iss));
            check_bit("unit_start R6", int'(unit_start), exp_s);
            check_bit("wb_grant R7 R8 R9", int'(wb_grant), exp_g);
            @(posedge clk);
            for (int i = 0; i < 4; i++) begin
                if (mbusy[i]) begin
                    if (mcnt[i] == 0) begin
                        if (best == i) mbusy[i] = 0;
                    end else begin
                        mcnt[i]--;
                    end
                end
            end
            if (exp_iss) begin
                mbusy[cur.unit] = 1;
                mcnt[cur.unit]  = lat[cur.unit] - 1;
                mde[cur.unit]   = cur.de;
                mdfp[cur.unit]  = cur.dfp;
                mdst[cur.unit]  = cur.dst;
            end
            if (exp_iss || !cur.vld) begin
                pc++;
                cur = (pc < N_DIR) ? directed(pc) : random_ins();
            end
            cyc++;
        end
        if (cyc >= LIMIT) begin
            fails++;
            $display("FAIL program stalled actual=%0d expected=%0d", pc, N_DIR + N_RAND);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule